// File: doc/BRIEF.md
# Empty-Only Dual-Clock FIFO

This block carries data words from one clock domain into another, unrelated one. Words written on the write clock go into a small dual-port memory. The read clock domain pulls them out in the order they arrived. Both address pointers count in Gray code. The write pointer reaches the read domain through a two-stage synchronizer, so at most one bit of it is in motion when the reader samples it.

The block is meant for links where the consumer always drains faster than the producer fills on average, so the buffer never runs out of room. For that reason it has no full detection. Each pointer is exactly log2(DEPTH) bits wide, with no extra wrap bit. The only comparison left is the one between the read pointer and the synchronized write pointer. That comparison produces a registered empty flag in the read domain.

The writer may assert its enable on any cycle. The reader consumes a word by asserting its enable while the empty flag is low, and the word appears on the registered data output after that read clock edge.

Top module: `eo_afifo`

## Requirements
- R1: While either domain's reset is held low and on the first cycle after its release, `rd_empty` is 1 and `rd_data` is 0. Reset is synchronous and active low.
- R2: Every word written is read out exactly once and in write order, for read clocks faster than, equal to and slower than the write clock, provided fewer than DEPTH words are stored at any time.
- R3: When an accepted read removes the only stored word and no write is in flight, `rd_empty` is 1 after that same read clock edge.
- R4: After a write into an empty FIFO, `rd_empty` stays 1 for at least two read clock edges that follow the write clock edge, and falls by the fifth such edge.
- R5: A read request while `rd_empty` is 1 is ignored: `rd_data` holds its value, and the next word read is the next word written.
- R6: The writer is never stalled. Every write clock edge with `wr_en` high stores `wr_data`, including back-to-back writes.
- R7: `rd_data` changes only on a read clock edge that accepts a read (`rd_en` high and `rd_empty` low). Otherwise it holds.
- R8: Each stored pointer moves by one Gray step per accepted access, so successive values differ in at most one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain synchronous reset, active low |
| wr_en | input | 1 | Store `wr_data` on this write clock edge |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain synchronous reset, active low |
| rd_en | input | 1 | Request the oldest word; accepted only while `rd_empty` is low |
| rd_data | output | DATA_W | Registered output word, updated on an accepted read |
| rd_empty | output | 1 | Registered flag: no word is visible to the reader |

## Verification
The assertions assume two things about the inputs. First, both resets are applied together and held for several cycles of each clock. Second, the writer never gets DEPTH words ahead of the reader, because nothing in the block detects or prevents overrun. The stimulus enforces the second point by gating every write on its own scoreboard count. That count only drops after a read has been checked, so it always over-estimates the real occupancy, and the bench keeps it at least three below the depth. The read clock period is varied between runs while both domains are idle, to cover faster, equal and slower readers.

// File: rtl/eo_afifo_pkg.sv
`timescale 1ns/1ps
// Package: eo_afifo_pkg
// Shared helpers for the empty-only dual-clock FIFO.
// Assumes pointer widths no larger than 32 bits.
package eo_afifo_pkg;

    // Converts a binary count into its reflected Gray code.
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/eo_gray_ptr.sv
`timescale 1ns/1ps
// Module: eo_gray_ptr
// Address pointer that keeps a binary count for memory addressing and a
// registered Gray copy for crossing clock domains. It also exposes the
// Gray value the pointer will take after this edge.
// Assumes AW >= 2 and that inc is synchronous to clk.
module eo_gray_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [AW-1:0] bin,
    output logic [AW-1:0] gray,
    output logic [AW-1:0] gray_nxt
);
    import eo_afifo_pkg::*;

    logic [AW-1:0] bin_inc;
    logic [AW-1:0] gray_inc;

    // Next binary and Gray values when the pointer steps.
    always_comb begin
        bin_inc  = bin + 1'b1;
        gray_inc = AW'(bin_to_gray(32'(bin_inc)));
        gray_nxt = inc ? gray_inc : gray;
    end

    // Pointer registers: step once per accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else if (inc) begin
            bin  <= bin_inc;
            gray <= gray_inc;
        end
    end

    // R8
    gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray ^ $past(gray)) <= 1);

endmodule

// File: rtl/eo_sync2.sv
`timescale 1ns/1ps
// Module: eo_sync2
// Two-stage synchronizer for a bus that changes at most one bit at a time
// (a Gray-coded pointer). It adds two destination clock cycles of delay.
// Assumes the source value is held in a register in the sending domain.
module eo_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture stage followed by a settling stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/eo_dpram.sv
`timescale 1ns/1ps
// Module: eo_dpram
// Simple dual-port memory: one write port on wclk and one registered read
// port on rclk. The memory contents are not reset. Only the output register
// is cleared, by the read domain's reset.
// Assumes the same address is never written and read in the same instant.
module eo_dpram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port: store one word per enabled write edge.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: load the output register only on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/eo_afifo.sv
`timescale 1ns/1ps
// Module: eo_afifo
// Dual-clock FIFO that produces only an empty flag. Pointers are
// log2(DEPTH) bits of Gray code with no wrap bit. The write pointer is
// synchronized into the read domain and compared there.
// Assumes DEPTH is a power of two (>= 4) and that the writer never gets
// DEPTH words ahead of the reader. Nothing detects or prevents overrun.
module eo_afifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wr_bin;
    logic [AW-1:0] wr_gray;
    logic [AW-1:0] wr_gray_nxt_unused;
    logic [AW-1:0] rd_bin;
    logic [AW-1:0] rd_gray;
    logic [AW-1:0] rd_gray_nxt;
    logic [AW-1:0] wr_gray_rd;
    logic          rd_accept;

    // A read is taken only while a word is visible.
    assign rd_accept = rd_en & ~rd_empty;

    eo_gray_ptr #(.AW(AW)) u_wr_ptr (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .inc      (wr_en),
        .bin      (wr_bin),
        .gray     (wr_gray),
        .gray_nxt (wr_gray_nxt_unused)
    );

    eo_gray_ptr #(.AW(AW)) u_rd_ptr (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .inc      (rd_accept),
        .bin      (rd_bin),
        .gray     (rd_gray),
        .gray_nxt (rd_gray_nxt)
    );

    eo_sync2 #(.W(AW)) u_wptr_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_rd)
    );

    eo_dpram #(.DW(DATA_W), .AW(AW)) u_mem (
        .wclk   (wr_clk),
        .we     (wr_en),
        .waddr  (wr_bin),
        .wdata  (wr_data),
        .rclk   (rd_clk),
        .rrst_n (rd_rst_n),
        .re     (rd_accept),
        .raddr  (rd_bin),
        .rdata  (rd_data)
    );

    // Empty flag: set when the read pointer catches the synchronized write pointer.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_empty <= 1'b1;
        end else begin
            rd_empty <= (wr_gray_rd == rd_gray_nxt);
        end
    end

    // R5
    empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_empty && rd_en) |=> $stable(rd_data));

    // R5
    empty_ptr_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_empty |=> $stable(rd_bin));

    // R7
    rd_idle_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_en |=> $stable(rd_data));

    // R3
    empty_set_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_accept && $stable(wr_gray_rd) && (wr_gray_rd == rd_gray_nxt)) |=> rd_empty);

endmodule

// File: tb/eo_afifo_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for eo_afifo: the writer pushes expected words into a
// queue, and a read-side monitor pops and compares them as they appear.
module eo_afifo_tb;
    localparam int DW    = 8;
    localparam int DEPTH = 16;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n, rd_rst_n;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [DW-1:0] rd_data;
    logic          rd_empty;

    realtime       rd_half = 2.5;
    int            checks = 0, fails = 0;
    int            rd_mode = 0;
    int            got = 0;
    bit            last_chk = 1'b0;
    bit            done = 1'b0;
    logic [DW-1:0] sb[$];

    eo_afifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    always #2.5 wr_clk = ~wr_clk;
    initial forever #(rd_half) rd_clk = ~rd_clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Read-side monitor: checks words and drives rd_en.
    initial begin : monitor
        bit            pend = 1'b0;
        bit            prev_en = 1'b0;
        logic [DW-1:0] last = '0;
        logic [DW-1:0] exp;
        int            rcnt = 0;
        rd_en = 1'b0;
        forever begin
            @(negedge rd_clk);
            if (pend) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", "read with nothing expected", rd_data, 0);
                end else begin
                    exp = sb.pop_front();
                    chk(rd_data == exp, "R2", "data order", rd_data, exp);
                    got++;
                    if (last_chk && sb.size() == 0)
                        chk(rd_empty == 1'b1, "R3", "empty after last read", rd_empty, 1);
                end
                last = rd_data;
            end else if (rd_rst_n) begin
                if (prev_en)
                    chk(rd_data == last, "R5", "data held on read while empty", rd_data, last);
                else
                    chk(rd_data == last, "R7", "data held while idle", rd_data, last);
            end
            rcnt++;
            case (rd_mode)
                1: rd_en = 1'b1;
                2: rd_en = (rcnt % 5) != 2;
                3: rd_en = (rcnt % 3) == 0;
                default: rd_en = 1'b0;
            endcase
            prev_en = rd_en && rd_empty;
            pend = rd_en && !rd_empty && rd_rst_n;
        end
    end

    task automatic wait_drain();
        for (int k = 0; k < 4000; k++) begin
            if (sb.size() == 0) break;
            @(negedge wr_clk);
        end
        repeat (20) @(negedge wr_clk);
    endtask

    // Stream n words, keeping the scoreboard count below DEPTH-3.
    task automatic stream(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            while (sb.size() >= DEPTH - 3) begin
                wr_en = 1'b0;
                @(negedge wr_clk);
            end
            if (i % 7 == 3) begin
                wr_en = 1'b0;
                @(negedge wr_clk);
            end
            wr_en   = 1'b1;
            wr_data = DW'(seed * 61 + i * 13 + (i >> 3));
            sb.push_back(wr_data);
            @(negedge wr_clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int n;
        int got0;
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        wr_en = 1'b0; wr_data = '0;
        repeat (6) @(negedge wr_clk);
        chk(rd_empty == 1'b1, "R1", "empty in reset", rd_empty, 1);
        chk(rd_data == '0, "R1", "data in reset", rd_data, 0);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R1", "empty after reset", rd_empty, 1);
        chk(rd_data == '0, "R1", "data after reset", rd_data, 0);

        // R5: read requests on an empty FIFO.
        rd_mode = 1;
        repeat (12) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R5", "still empty", rd_empty, 1);
        chk(rd_data == '0, "R5", "data untouched", rd_data, 0);
        rd_mode = 0;
        repeat (3) @(negedge rd_clk);

        // R4: empty flag latency after a single write.
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = 8'hA5; sb.push_back(8'hA5);
        @(posedge wr_clk);
        #1 wr_en = 1'b0;
        n = 0;
        while (rd_empty && n < 20) begin
            @(posedge rd_clk);
            #0.2;
            n++;
        end
        chk(n >= 2, "R4", "edges before empty falls (min)", n, 2);
        chk(n <= 5, "R4", "edges before empty falls (max)", n, 5);

        // R3 and R5: read the lone word, then the next read must return the next word.
        last_chk = 1'b1;
        rd_mode = 1;
        wait_drain();
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = 8'h3C; sb.push_back(8'h3C);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = 8'hC3; sb.push_back(8'hC3);
        @(negedge wr_clk);
        wr_en = 1'b0;
        wait_drain();
        chk(got == 3, "R5", "words read after empty reads", got, 3);
        last_chk = 1'b0;

        // R2 and R6: streams across clock ratios.
        for (int p = 0; p < 4; p++) begin
            rd_mode = 0;
            repeat (10) @(negedge wr_clk);
            case (p)
                0: rd_half = 2.5;
                1: rd_half = 1.75;
                2: rd_half = 4.0;
                default: rd_half = 6.5;
            endcase
            case (p)
                0: rd_mode = 2;
                1: rd_mode = 3;
                2: rd_mode = 1;
                default: rd_mode = 2;
            endcase
            got0 = got;
            stream(250, p + 1);
            wait_drain();
            chk(got - got0 == 250, "R6", "every write stored and read", got - got0, 250);
            chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
            chk(rd_empty == 1'b1, "R3", "empty after drain", rd_empty, 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule